// File: doc/BRIEF.md
# Gaussian Pulse Train Generator with Serial DAC Output

The block produces a repeating train of bell-shaped pulses as 12-bit unsigned codes and sends every code to an external four-channel DAC over a write-only SPI link that it masters. Each code travels in its own 32-bit command frame. The block raises chip select once the last bit has gone out, and that rising edge is what starts the DAC's conversion. Since one frame carries one sample, time inside the pulse train is counted in frames. A pulse is a fixed run of samples followed by baseline zeros until the pulse period ends.

The pulse shape is a binomial approximation of a Gaussian. It is computed at elaboration from the shape order, normalised so that its centre is 2^14, and then scaled by the selected peak code. A quadrature rotary encoder steps the repetition period up or down, clamped at both ends. The defaults span about 2 kHz down to about 454 Hz when driven from a 50 MHz clock. A push button steps the peak code through a set of evenly spaced levels. With a 2.5 V reference those levels run from about 0.86 V to 1.6 V. A new rate or amplitude is picked up only when a pulse begins, so a pulse is never a mix of two settings.

Top module: `gp_dac_pulse_gen`

## Requirements
- R1: Every frame has exactly 32 SCK rising edges while dac_cs_n is low. dac_cs_n stays high for at least CS_HIGH (at least 2) clock cycles between frames. SCK is low whenever dac_cs_n is high.
- R2: Frame bits are sent MSB first. Bits 31:24 are 0, bits 23:20 are 4'b0011 (write and update), bits 19:16 are the DAC_CHAN parameter, bits 15:4 are the sample, and bits 3:0 are 0.
- R3: dac_mosi changes only while SCK is low, so it is stable at every SCK rising edge.
- R4: Sample k (k = 0..N, N = SHAPE_ORDER) of a pulse with peak code P equals (floor(C(N,k)*16384 / C(N,N/2)) * P) >> 14, where C is the binomial coefficient. The centre sample therefore equals P.
- R5: At rate index r, pulse centres are T(r) = PERIOD_MAX - floor((PERIOD_MAX-PERIOD_MIN)*r/(RATE_STEPS-1)) frames apart. Every frame between pulses carries sample 0.
- R6: A rising edge on enc_a while enc_b is low raises the rate index by one. A rising edge on enc_a while enc_b is high lowers it by one. The index is clamped to 0..RATE_STEPS-1.
- R7: A rising edge on enc_push advances the amplitude index by one and wraps from AMP_LEVELS-1 to 0. Index a selects peak P(a) = PEAK_MIN + floor((PEAK_MAX-PEAK_MIN)*a/(AMP_LEVELS-1)).
- R8: Rate and amplitude settings are latched only at the first sample of a pulse. A change made during a pulse leaves the rest of that pulse unchanged.
- R9: During reset dac_cs_n is high and SCK is low. After reset the rate index and amplitude index are both 0, and the first frame carries sample 0 of a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_a | input | 1 | Encoder quadrature phase A (asynchronous) |
| enc_b | input | 1 | Encoder quadrature phase B (asynchronous) |
| enc_push | input | 1 | Encoder push button, advances amplitude level |
| dac_sck | output | 1 | SPI serial clock, idle low |
| dac_mosi | output | 1 | SPI serial data to the DAC, MSB first |
| dac_cs_n | output | 1 | Active-low DAC chip select; its rising edge starts a conversion |

## Verification
The hardest case to reach is a control change that lands in the middle of a pulse. Only the latch at the pulse's first sample keeps that pulse intact, and the change is visible only as a difference in the frames that follow. The bench watches the decoded frames until a zero sample is followed by a nonzero one, which marks the start of a pulse, and presses the button at once. It then checks that every remaining sample of that pulse still matches the old peak and that the next pulse uses the new one. Rate changes are checked by the spacing of pulse centres. The bench skips the first centre after a change because that pulse may have started under the old setting.

// File: rtl/gp_pkg.sv
package gp_pkg;

    localparam int FRAME_BITS = 32;
    localparam int SAMPLE_W   = 12;
    localparam int NORM_SHIFT = 14;
    localparam logic [3:0] CMD_WRITE_UPDATE = 4'b0011;

    typedef enum logic {
        SPI_GAP   = 1'b0,
        SPI_SHIFT = 1'b1
    } spi_state_e;

    // binomial coefficient, exact at each step of the product
    function automatic longint unsigned binom(input int n, input int k);
        longint unsigned r;
        r = 1;
        for (int i = 1; i <= k; i++) begin
            r = r * longint'(n - k + i) / longint'(i);
        end
        return r;
    endfunction

    function automatic logic [FRAME_BITS-1:0] dac_frame(input logic [3:0] chan,
                                                        input logic [SAMPLE_W-1:0] code);
        return {8'h00, CMD_WRITE_UPDATE, chan, code, 4'h0};
    endfunction

endpackage

// File: rtl/gp_quad_ctrl.sv
module gp_quad_ctrl #(
    parameter int RATE_STEPS = 16,
    parameter int AMP_LEVELS = 8,
    localparam int RATE_W = $clog2(RATE_STEPS),
    localparam int AMP_W  = $clog2(AMP_LEVELS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enc_a,
    input  logic              enc_b,
    input  logic              enc_push,
    output logic [RATE_W-1:0] rate_idx,
    output logic [AMP_W-1:0]  amp_idx
);

    localparam logic [RATE_W-1:0] RATE_TOP = RATE_W'(RATE_STEPS - 1);
    localparam logic [AMP_W-1:0]  AMP_TOP  = AMP_W'(AMP_LEVELS - 1);

    typedef struct packed {
        logic [1:0]        a_sync;
        logic [1:0]        b_sync;
        logic [1:0]        p_sync;
        logic              a_prev;
        logic              p_prev;
        logic [RATE_W-1:0] rate;
        logic [AMP_W-1:0]  amp;
    } quad_state_t;

    quad_state_t st_d, st_q;
    logic step_evt, step_up, push_evt;

    always_comb begin
        st_d        = st_q;
        st_d.a_sync = {st_q.a_sync[0], enc_a};
        st_d.b_sync = {st_q.b_sync[0], enc_b};
        st_d.p_sync = {st_q.p_sync[0], enc_push};
        st_d.a_prev = st_q.a_sync[1];
        st_d.p_prev = st_q.p_sync[1];

        step_evt = st_q.a_sync[1] & ~st_q.a_prev;
        step_up  = ~st_q.b_sync[1];
        push_evt = st_q.p_sync[1] & ~st_q.p_prev;

        if (step_evt) begin
            if (step_up) begin
                if (st_q.rate != RATE_TOP) st_d.rate = st_q.rate + 1'b1;
            end else begin
                if (st_q.rate != '0) st_d.rate = st_q.rate - 1'b1;
            end
        end

        if (push_evt) begin
            st_d.amp = (st_q.amp == AMP_TOP) ? '0 : st_q.amp + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rate_idx = st_q.rate;
    assign amp_idx  = st_q.amp;

    // R6: stepping up at the top end leaves the index at the top
    p_rate_clamp_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (step_evt && step_up && st_q.rate == RATE_TOP) |=> (st_q.rate == RATE_TOP));

    // R6: the rate index only moves right after a decoded detent
    p_rate_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.rate != $past(st_q.rate)) |-> $past(step_evt));

    // R7: amplitude index wraps to zero after the last level
    p_amp_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (push_evt && st_q.amp == AMP_TOP) |=> (st_q.amp == '0));

endmodule

// File: rtl/gp_pulse_seq.sv
module gp_pulse_seq #(
    parameter int SHAPE_ORDER = 16,
    parameter int RATE_STEPS  = 16,
    parameter int PERIOD_MIN  = 189,
    parameter int PERIOD_MAX  = 834,
    parameter int AMP_LEVELS  = 8,
    parameter int PEAK_MIN    = 1409,
    parameter int PEAK_MAX    = 2621,
    localparam int RATE_W = $clog2(RATE_STEPS),
    localparam int AMP_W  = $clog2(AMP_LEVELS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [RATE_W-1:0]             rate_idx,
    input  logic [AMP_W-1:0]              amp_idx,
    input  logic                          advance,
    output logic [gp_pkg::SAMPLE_W-1:0]   sample
);
    import gp_pkg::*;

    localparam int SHAPE_LEN = SHAPE_ORDER + 1;
    localparam int IDX_W     = $clog2(SHAPE_LEN);
    localparam int SLOT_W    = $clog2(PERIOD_MAX + 1);
    localparam int NORM_W    = NORM_SHIFT + 1;
    localparam int PROD_W    = NORM_W + SAMPLE_W;
    localparam longint unsigned CENTER_C = binom(SHAPE_ORDER, SHAPE_ORDER / 2);

    logic [NORM_W-1:0]   norm_lut   [SHAPE_LEN];
    logic [SLOT_W-1:0]   period_lut [RATE_STEPS];
    logic [SAMPLE_W-1:0] peak_lut   [AMP_LEVELS];

    for (genvar gi = 0; gi < SHAPE_LEN; gi++) begin : g_shape
        localparam longint unsigned NV = (binom(SHAPE_ORDER, gi) << NORM_SHIFT) / CENTER_C;
        assign norm_lut[gi] = NORM_W'(NV);
    end

    for (genvar gr = 0; gr < RATE_STEPS; gr++) begin : g_period
        localparam int PV = PERIOD_MAX - ((PERIOD_MAX - PERIOD_MIN) * gr) / (RATE_STEPS - 1);
        assign period_lut[gr] = SLOT_W'(PV);
    end

    for (genvar ga = 0; ga < AMP_LEVELS; ga++) begin : g_peak
        localparam int KV = PEAK_MIN + ((PEAK_MAX - PEAK_MIN) * ga) / (AMP_LEVELS - 1);
        assign peak_lut[ga] = SAMPLE_W'(KV);
    end

    typedef struct packed {
        logic [SLOT_W-1:0]   slot;
        logic [SLOT_W-1:0]   period;
        logic [SAMPLE_W-1:0] peak;
    } seq_state_t;

    seq_state_t st_d, st_q;
    logic [SLOT_W-1:0] slot_next;
    logic              in_shape;
    logic [NORM_W-1:0] norm_sel;
    logic [PROD_W-1:0] prod;

    always_comb begin
        st_d      = st_q;
        slot_next = (st_q.slot == st_q.period - 1'b1) ? '0 : st_q.slot + 1'b1;
        if (advance) begin
            st_d.slot = slot_next;
            if (slot_next == '0) begin
                st_d.period = period_lut[rate_idx];
                st_d.peak   = peak_lut[amp_idx];
            end
        end

        in_shape = (st_q.slot < SLOT_W'(SHAPE_LEN));
        norm_sel = in_shape ? norm_lut[st_q.slot[IDX_W-1:0]] : '0;
        prod     = norm_sel * st_q.peak;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.slot   <= '0;
            st_q.period <= SLOT_W'(PERIOD_MAX);
            st_q.peak   <= SAMPLE_W'(PEAK_MIN);
        end else begin
            st_q <= st_d;
        end
    end

    assign sample = SAMPLE_W'(prod >> NORM_SHIFT);

    // R8: the latched settings do not move inside a pulse
    p_peak_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.slot != '0) |-> ($stable(st_q.peak) && $stable(st_q.period)));

    // R5: the slot counter stays within the latched period
    p_slot_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.slot < st_q.period);

endmodule

// File: rtl/gp_spi_tx.sv
module gp_spi_tx #(
    parameter int SCK_HALF = 2,
    parameter int CS_HIGH  = 4,
    parameter int DAC_CHAN = 0
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [gp_pkg::SAMPLE_W-1:0] sample,
    output logic                        sck,
    output logic                        mosi,
    output logic                        cs_n,
    output logic                        advance
);
    import gp_pkg::*;

    localparam int DIV_W = $clog2(SCK_HALF + 1);
    localparam int GAP_W = $clog2(CS_HIGH + 1);
    localparam int BIT_W = $clog2(FRAME_BITS);
    localparam logic [3:0] CHAN = 4'(DAC_CHAN);

    typedef struct packed {
        spi_state_e            state;
        logic [GAP_W-1:0]      gap;
        logic [DIV_W-1:0]      div;
        logic [BIT_W-1:0]      bitn;
        logic                  sck;
        logic                  cs_n;
        logic                  advance;
        logic [FRAME_BITS-1:0] shreg;
    } spi_state_t;

    spi_state_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.advance = 1'b0;
        case (st_q.state)
            SPI_GAP: begin
                if (st_q.gap == GAP_W'(CS_HIGH - 1)) begin
                    st_d.state = SPI_SHIFT;
                    st_d.cs_n  = 1'b0;
                    st_d.sck   = 1'b0;
                    st_d.div   = '0;
                    st_d.bitn  = '0;
                    st_d.shreg = dac_frame(CHAN, sample);
                end else begin
                    st_d.gap = st_q.gap + 1'b1;
                end
            end
            SPI_SHIFT: begin
                if (st_q.div == DIV_W'(SCK_HALF - 1)) begin
                    st_d.div = '0;
                    if (!st_q.sck) begin
                        st_d.sck = 1'b1;
                    end else begin
                        st_d.sck = 1'b0;
                        if (st_q.bitn == BIT_W'(FRAME_BITS - 1)) begin
                            st_d.state   = SPI_GAP;
                            st_d.cs_n    = 1'b1;
                            st_d.gap     = '0;
                            st_d.advance = 1'b1;
                        end else begin
                            st_d.bitn  = st_q.bitn + 1'b1;
                            st_d.shreg = {st_q.shreg[FRAME_BITS-2:0], 1'b0};
                        end
                    end
                end else begin
                    st_d.div = st_q.div + 1'b1;
                end
            end
            default: st_d.state = SPI_GAP;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.state <= SPI_GAP;
            st_q.cs_n  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign sck     = st_q.sck;
    assign mosi    = st_q.shreg[FRAME_BITS-1];
    assign cs_n    = st_q.cs_n;
    assign advance = st_q.advance;

    // checker state: SCK rising edges counted per frame
    logic [5:0] chk_rises;
    logic       chk_sck_prev, chk_cs_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chk_rises    <= '0;
            chk_sck_prev <= 1'b0;
            chk_cs_prev  <= 1'b1;
        end else begin
            chk_sck_prev <= st_q.sck;
            chk_cs_prev  <= st_q.cs_n;
            if (st_q.cs_n && chk_cs_prev)              chk_rises <= '0;
            else if (st_q.sck && !chk_sck_prev && !st_q.cs_n) chk_rises <= chk_rises + 1'b1;
        end
    end

    // R1: a frame closes after exactly 32 clock pulses
    p_frame_len_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cs_n && !chk_cs_prev) |-> (chk_rises == 6'd32));

    // R1: serial clock rests low while deselected
    p_sck_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cs_n |-> !st_q.sck);

    // R3: data does not move at a rising serial clock edge
    p_mosi_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.sck) |-> $stable(st_q.shreg[FRAME_BITS-1]));

endmodule

// File: rtl/gp_dac_pulse_gen.sv
module gp_dac_pulse_gen #(
    parameter int SCK_HALF    = 2,
    parameter int CS_HIGH     = 4,
    parameter int DAC_CHAN    = 0,
    parameter int SHAPE_ORDER = 16,
    parameter int RATE_STEPS  = 16,
    parameter int PERIOD_MIN  = 189,
    parameter int PERIOD_MAX  = 834,
    parameter int AMP_LEVELS  = 8,
    parameter int PEAK_MIN    = 1409,
    parameter int PEAK_MAX    = 2621
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enc_a,
    input  logic enc_b,
    input  logic enc_push,
    output logic dac_sck,
    output logic dac_mosi,
    output logic dac_cs_n
);
    localparam int RATE_W = $clog2(RATE_STEPS);
    localparam int AMP_W  = $clog2(AMP_LEVELS);

    logic [RATE_W-1:0]           rate_idx;
    logic [AMP_W-1:0]            amp_idx;
    logic [gp_pkg::SAMPLE_W-1:0] sample;
    logic                        advance;

    gp_quad_ctrl #(
        .RATE_STEPS (RATE_STEPS),
        .AMP_LEVELS (AMP_LEVELS)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .enc_a    (enc_a),
        .enc_b    (enc_b),
        .enc_push (enc_push),
        .rate_idx (rate_idx),
        .amp_idx  (amp_idx)
    );

    gp_pulse_seq #(
        .SHAPE_ORDER (SHAPE_ORDER),
        .RATE_STEPS  (RATE_STEPS),
        .PERIOD_MIN  (PERIOD_MIN),
        .PERIOD_MAX  (PERIOD_MAX),
        .AMP_LEVELS  (AMP_LEVELS),
        .PEAK_MIN    (PEAK_MIN),
        .PEAK_MAX    (PEAK_MAX)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .rate_idx (rate_idx),
        .amp_idx  (amp_idx),
        .advance  (advance),
        .sample   (sample)
    );

    gp_spi_tx #(
        .SCK_HALF (SCK_HALF),
        .CS_HIGH  (CS_HIGH),
        .DAC_CHAN (DAC_CHAN)
    ) u_spi (
        .clk     (clk),
        .rst_n   (rst_n),
        .sample  (sample),
        .sck     (dac_sck),
        .mosi    (dac_mosi),
        .cs_n    (dac_cs_n),
        .advance (advance)
    );

endmodule

// File: tb/tb_gp_dac_pulse_gen.sv
module tb_gp_dac_pulse_gen;

    localparam int N     = 8;
    localparam int RST   = 4;
    localparam int ALEV  = 4;
    localparam int PMIN  = 20;
    localparam int PMAX  = 40;
    localparam int PKMIN = 1409;
    localparam int PKMAX = 2621;
    localparam int CHAN  = 2;
    localparam int CAP   = 135;

    logic clk = 1'b0, rst_n = 1'b0;
    logic enc_a = 1'b0, enc_b = 1'b0, enc_push = 1'b0;
    logic dac_sck, dac_mosi, dac_cs_n;

    always #5 clk = ~clk;

    gp_dac_pulse_gen #(
        .SCK_HALF (1), .CS_HIGH (2), .DAC_CHAN (CHAN), .SHAPE_ORDER (N),
        .RATE_STEPS (RST), .PERIOD_MIN (PMIN), .PERIOD_MAX (PMAX),
        .AMP_LEVELS (ALEV), .PEAK_MIN (PKMIN), .PEAK_MAX (PKMAX)
    ) dut (
        .clk (clk), .rst_n (rst_n), .enc_a (enc_a), .enc_b (enc_b),
        .enc_push (enc_push), .dac_sck (dac_sck), .dac_mosi (dac_mosi),
        .dac_cs_n (dac_cs_n)
    );

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    // SPI frame monitor
    logic [31:0] flog [0:1023];
    int log_n = 0, bad_len = 0, mon_bits = 0;
    logic [31:0] mon_sh = '0;
    bit mon_on = 1'b0;

    always @(negedge dac_cs_n) if (rst_n) begin mon_on = 1'b1; mon_bits = 0; end
    always @(posedge dac_sck) if (mon_on && !dac_cs_n) begin
        mon_sh = {mon_sh[30:0], dac_mosi};
        mon_bits++;
    end
    always @(posedge dac_cs_n) if (mon_on) begin
        if (mon_bits != 32) bad_len++;
        if (log_n < 1024) flog[log_n] = mon_sh;
        log_n++;
        mon_on = 1'b0;
    end

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    function automatic longint bn(input int n, input int k);
        longint r = 1;
        for (int i = 1; i <= k; i++) r = r * (n - k + i) / i;
        return r;
    endfunction
    function automatic int exp_peak(input int a);
        return PKMIN + ((PKMAX - PKMIN) * a) / (ALEV - 1);
    endfunction
    function automatic int exp_period(input int r);
        return PMAX - ((PMAX - PMIN) * r) / (RST - 1);
    endfunction
    function automatic int exp_sample(input int k, input int pk);
        longint nv = (bn(N, k) * 16384) / bn(N, N / 2);
        return int'((nv * pk) >>> 14);
    endfunction
    function automatic int smp(input int j);
        return int'(flog[j][15:4]);
    endfunction

    task automatic capture(input int n);
        @(negedge clk);
        log_n = 0;
        bad_len = 0;
        wait (log_n >= n);
        @(negedge clk);
    endtask

    task automatic detent(input bit cw);
        enc_b = ~cw;
        repeat (4) @(negedge clk);
        enc_a = 1'b1;
        repeat (8) @(negedge clk);
        enc_a = 1'b0;
        repeat (4) @(negedge clk);
        enc_b = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic press();
        enc_push = 1'b1;
        repeat (8) @(negedge clk);
        enc_push = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    // capture frames and check frame format, shape, baseline and spacing
    task automatic t_pulse_train(input int r, input int a, input string tag);
        int c[3];
        int nc = 0;
        int hdr_bad = 0;
        int pk = exp_peak(a);
        capture(CAP);
        for (int j = 0; j < CAP; j++)
            if (flog[j][31:24] != 8'h00 || flog[j][23:20] != 4'b0011 ||
                flog[j][19:16] != 4'(CHAN) || flog[j][3:0] != 4'h0) hdr_bad++;
        chk(hdr_bad == 0, {"R2 R3 frame header ", tag}, hdr_bad, 0);
        chk(bad_len == 0, {"R1 bits per frame ", tag}, bad_len, 0);
        for (int j = 1; j < CAP - 1 && nc < 3; j++)
            if (smp(j) > smp(j - 1) && smp(j) > smp(j + 1)) begin c[nc] = j; nc++; end
        chk(nc == 3, {"R5 pulse centres found ", tag}, nc, 3);
        if (nc == 3) begin
            int sbad = -1, sact = 0, sexp = 0, zbad = 0;
            chk(smp(c[1]) == pk, {"R7 peak code ", tag}, smp(c[1]), pk);
            chk(c[2] - c[1] == exp_period(r), {"R5 R6 pulse period ", tag},
                c[2] - c[1], exp_period(r));
            for (int k = 0; k <= N; k++) begin
                int j = c[1] - N / 2 + k;
                if (sbad < 0 && smp(j) != exp_sample(k, pk)) begin
                    sbad = k; sact = smp(j); sexp = exp_sample(k, pk);
                end
            end
            chk(sbad < 0, {"R4 pulse shape ", tag}, sact, sexp);
            for (int j = c[1] + N / 2 + 1; j < c[2] - N / 2; j++)
                if (smp(j) != 0) zbad++;
            chk(zbad == 0, {"R5 baseline zeros ", tag}, zbad, 0);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (5) @(negedge clk);
        chk(dac_cs_n === 1'b1, "R9 cs_n high in reset", int'(dac_cs_n), 1);
        chk(dac_sck === 1'b0, "R9 sck low in reset", int'(dac_sck), 0);
        rst_n = 1'b1;
        wait (log_n >= 1);
        @(negedge clk);
        chk(smp(0) == exp_sample(0, exp_peak(0)), "R9 first frame is sample 0",
            smp(0), exp_sample(0, exp_peak(0)));
    endtask

    // R8: press the button right after a pulse starts; the pulse keeps its old peak
    task automatic t_midpulse(input int a_old);
        int j = 1;
        int bad = 0;
        @(negedge clk);
        log_n = 0;
        forever begin
            wait (log_n > j);
            if (smp(j - 1) == 0 && smp(j) != 0) break;
            j++;
        end
        press();
        wait (log_n > j + N);
        for (int k = 0; k <= N; k++)
            if (smp(j + k) != exp_sample(k, exp_peak(a_old))) bad++;
        chk(bad == 0, "R8 pulse unchanged by mid-pulse press", bad, 0);
    endtask

    initial begin
        t_reset();
        t_pulse_train(0, 0, "default");
        detent(1'b1);
        t_pulse_train(1, 0, "R6 one step up");
        for (int i = 0; i < 5; i++) detent(1'b1);
        t_pulse_train(RST - 1, 0, "R6 clamp top");
        detent(1'b0);
        t_pulse_train(RST - 2, 0, "R6 one step down");
        for (int i = 0; i < 4; i++) detent(1'b0);
        t_pulse_train(0, 0, "R6 clamp bottom");
        t_midpulse(0);
        t_pulse_train(0, 1, "R7 level 1");
        press();
        press();
        t_pulse_train(0, 3, "R7 level 3");
        press();
        t_pulse_train(0, 0, "R7 wrap");
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule